// File: doc/BRIEF.md
# Serial Clock Command Front End

This block sits between a host and the time-keeping core of a serial-access real-time clock. The host presents a 3-bit parallel command, a serial data line, a data clock and a strobe. A rising strobe latches a new command. When the parallel code is the escape value 3'b111, the block obeys an extended 4-bit command instead. The host loads that command serially into a small command register. The active command picks one of four register actions:

- hold
- shift
- time set, which copies the data register into the time counter
- time read, which copies the time counter into the data register

The data register is 48 bits wide. The parallel path uses only its lower 40 bits, which leaves out the year byte. The extended path uses all 48 bits. In extended shift mode, the command register is chained in front of the data register, so the shifted chain is 52 bits long. The serial output carries either the register LSB or an externally supplied 1 Hz tick, depending on the mode. After a transfer, the data register is frozen until the next strobe.

The host strobe, data clock and data pins are asynchronous to the system clock. They pass through a synchronizer. Edges are then detected in the system clock domain.

Top module: `rtc_cmd_frontend`

## Requirements
- R1: After reset the block is in hold mode on the parallel path, both registers are zero, `time_hold_o` is low and `data_o` follows `tick_1hz_i`.
- R2: A rising edge of `strobe_i` latches `cmd_i`. The parallel codes are 000 hold, 001 shift, 010 time set and 011 time read. Codes 100, 101 and 110 select hold.
- R3: A strobe with `cmd_i` = 111 selects the extended path, with the mode taken from the 4-bit command register. Register values 0000, 0001, 0010 and 0011 select hold, shift, time set and time read. Any other value selects hold.
- R4: In parallel shift mode, each rising edge of `data_clk_i` moves data register bits 39:0 one place toward bit 0, with `data_i` entering bit 39. Bits 47:40 are untouched.
- R5: In extended shift mode, one 52-bit chain shifts on each data clock. The chain runs from `data_i` into command register bit 3, down to bit 0, then into data register bit 47, down to bit 0.
- R6: While the extended path is active, the command register shifts on every data clock edge (`data_i` enters bit 3) in every mode. It never shifts on the parallel path.
- R7: `data_o` equals data register bit 0 in shift and time set modes. It equals `tick_1hz_i` in hold and time read modes.
- R8: Time set gives a one-cycle `time_wr_o` pulse, with `time_o` carrying the data register. On the parallel path bits 47:40 of `time_o` read zero. `time_year_wr_o` pulses only on the extended path. `time_hold_o` stays high until the next command.
- R9: Time read loads `time_i` into the data register. The parallel path loads bits 39:0 and clears bits 47:40. The extended path loads all 48 bits.
- R10: After time set or time read, the data register ignores data clock edges until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Parallel command code |
| data_i | input | 1 | Serial data input |
| data_clk_i | input | 1 | Serial data clock, rising edge active |
| strobe_i | input | 1 | Command strobe, rising edge active |
| tick_1hz_i | input | 1 | 1 Hz square wave from the time-keeping core |
| time_i | input | 48 | Current time counter value |
| data_o | output | 1 | Serial data output |
| time_o | output | 48 | Value written to the time counter |
| time_wr_o | output | 1 | One-cycle time counter write pulse |
| time_year_wr_o | output | 1 | Write pulse qualifier for the year byte |
| time_hold_o | output | 1 | Holds the time counter during time set |

## Verification
The assertions check every cycle that:
- a locked data register stays stable;
- the command register never moves on the parallel path;
- the year byte survives parallel shifting;
- the extended chain feeds command register bit 0 into data register bit 47;
- write pulses are qualified correctly.

Only the bench scenarios can show the rest:
- the bit order of a full 40-bit and 52-bit shift;
- that the values captured on time set and loaded on time read are correct;
- the escape gating and the serial command load sequence;
- the fallback of undefined codes to hold.

// File: rtl/rtc_cmd_pkg.sv
package rtc_cmd_pkg;

  localparam int PAR_CMD_W = 3;
  localparam int SER_CMD_W = 4;
  localparam logic [PAR_CMD_W-1:0] PAR_ESCAPE = 3'b111;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_SET   = 2'd2,
    MODE_READ  = 2'd3
  } rtc_mode_e;

  function automatic rtc_mode_e decode_par(input logic [PAR_CMD_W-1:0] c);
    if (c[2]) return MODE_HOLD;
    return rtc_mode_e'(c[1:0]);
  endfunction

  function automatic rtc_mode_e decode_ser(input logic [SER_CMD_W-1:0] c);
    if (c[3:2] != 2'b00) return MODE_HOLD;
    return rtc_mode_e'(c[1:0]);
  endfunction

endpackage

// File: rtl/rtc_cmd_sync.sv
module rtc_cmd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_cmd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_rise_i,
  input  logic [PAR_CMD_W-1:0] cmd_par_i,
  input  logic [SER_CMD_W-1:0] cmd_ser_i,
  output rtc_mode_e            mode_o,
  output logic                 ser_o,
  output logic                 locked_o,
  output logic                 set_pulse_o,
  output logic                 read_pulse_o
);

  rtc_mode_e mode_q, mode_d;
  logic      ser_q, locked_q, set_q, read_q, esc;

  assign esc    = (cmd_par_i == PAR_ESCAPE);
  assign mode_d = esc ? decode_ser(cmd_ser_i) : decode_par(cmd_par_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_HOLD;
      ser_q    <= 1'b0;
      locked_q <= 1'b0;
      set_q    <= 1'b0;
      read_q   <= 1'b0;
    end else begin
      set_q  <= 1'b0;
      read_q <= 1'b0;
      if (strobe_rise_i) begin
        mode_q   <= mode_d;
        ser_q    <= esc;
        locked_q <= (mode_d == MODE_SET) || (mode_d == MODE_READ);
        set_q    <= (mode_d == MODE_SET);
        read_q   <= (mode_d == MODE_READ);
      end
    end
  end

  assign mode_o       = mode_q;
  assign ser_o        = ser_q;
  assign locked_o     = locked_q;
  assign set_pulse_o  = set_q;
  assign read_pulse_o = read_q;

  // R3
  esc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_rise_i && (cmd_par_i != PAR_ESCAPE) |=> !ser_o);

  // R10
  xfer_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pulse_o || read_pulse_o) |-> locked_o);

  // R8
  set_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pulse_o |=> !set_pulse_o);

endmodule

// File: rtl/rtc_cmd_shreg.sv
module rtc_cmd_shreg
  import rtc_cmd_pkg::*;
#(
  parameter int DW = 48,
  parameter int PW = 40,
  parameter int CW = SER_CMD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_rise_i,
  input  logic          data_i,
  input  rtc_mode_e     mode_i,
  input  logic          ser_i,
  input  logic          locked_i,
  input  logic          load_i,
  input  logic [DW-1:0] time_i,
  output logic [DW-1:0] sreg_o,
  output logic [CW-1:0] creg_o
);

  localparam logic [DW-1:0] PAR_MASK = {{(DW-PW){1'b0}}, {PW{1'b1}}};

  logic [DW-1:0] sreg_q;
  logic [CW-1:0] creg_q;
  logic          shift_data;

  assign shift_data = shift_rise_i && (mode_i == MODE_SHIFT) && !locked_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
    end else if (load_i) begin
      sreg_q <= ser_i ? time_i : (time_i & PAR_MASK);
    end else if (shift_data) begin
      if (ser_i) sreg_q <= {creg_q[0], sreg_q[DW-1:1]};
      else       sreg_q[PW-1:0] <= {data_i, sreg_q[PW-1:1]};
    end
  end

  // command register moves on every data clock while the extended path is active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  creg_q <= '0;
    else if (shift_rise_i && ser_i) creg_q <= {data_i, creg_q[CW-1:1]};
  end

  assign sreg_o = sreg_q;
  assign creg_o = creg_q;

  // R10
  locked_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i && !load_i |=> $stable(sreg_q));

  // R6
  par_creg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_i |=> $stable(creg_q));

  // R4
  par_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_i && !load_i |=> $stable(sreg_q[DW-1:PW]));

  // R5
  ser_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_i && shift_data && !load_i |=> sreg_q[DW-1] == $past(creg_q[0]));

endmodule

// File: rtl/rtc_cmd_frontend.sv
module rtc_cmd_frontend
  import rtc_cmd_pkg::*;
#(
  parameter int DATA_W      = 48,
  parameter int PAR_DATA_W  = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PAR_CMD_W-1:0] cmd_i,
  input  logic                 data_i,
  input  logic                 data_clk_i,
  input  logic                 strobe_i,
  input  logic                 tick_1hz_i,
  input  logic [DATA_W-1:0]    time_i,
  output logic                 data_o,
  output logic [DATA_W-1:0]    time_o,
  output logic                 time_wr_o,
  output logic                 time_year_wr_o,
  output logic                 time_hold_o
);

  localparam int SYNC_W = PAR_CMD_W + 3;
  localparam logic [DATA_W-1:0] PAR_MASK = {{(DATA_W-PAR_DATA_W){1'b0}}, {PAR_DATA_W{1'b1}}};

  logic [SYNC_W-1:0]    sync_q;
  logic [PAR_CMD_W-1:0] cmd_s;
  logic                 data_s, dclk_s, strobe_s;
  logic                 dclk_d, strobe_d, dclk_rise, strobe_rise;
  rtc_mode_e            mode;
  logic                 ser, locked, set_pulse, read_pulse;
  logic [DATA_W-1:0]    sreg;
  logic [SER_CMD_W-1:0] creg;

  rtc_cmd_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({strobe_i, data_clk_i, data_i, cmd_i}),
    .q_o    (sync_q)
  );

  assign {strobe_s, dclk_s, data_s, cmd_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_d   <= 1'b0;
      strobe_d <= 1'b0;
    end else begin
      dclk_d   <= dclk_s;
      strobe_d <= strobe_s;
    end
  end

  assign dclk_rise   = dclk_s & ~dclk_d;
  assign strobe_rise = strobe_s & ~strobe_d;

  rtc_cmd_decode u_decode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strobe_rise_i (strobe_rise),
    .cmd_par_i     (cmd_s),
    .cmd_ser_i     (creg),
    .mode_o        (mode),
    .ser_o         (ser),
    .locked_o      (locked),
    .set_pulse_o   (set_pulse),
    .read_pulse_o  (read_pulse)
  );

  rtc_cmd_shreg #(.DW(DATA_W), .PW(PAR_DATA_W), .CW(SER_CMD_W)) u_shreg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .shift_rise_i (dclk_rise),
    .data_i       (data_s),
    .mode_i       (mode),
    .ser_i        (ser),
    .locked_i     (locked),
    .load_i       (read_pulse),
    .time_i       (time_i),
    .sreg_o       (sreg),
    .creg_o       (creg)
  );

  assign data_o         = (mode == MODE_SHIFT || mode == MODE_SET) ? sreg[0] : tick_1hz_i;
  assign time_o         = ser ? sreg : (sreg & PAR_MASK);
  assign time_wr_o      = set_pulse;
  assign time_year_wr_o = set_pulse & ser;
  assign time_hold_o    = (mode == MODE_SET);

  // R8
  year_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_year_wr_o |-> time_wr_o);

  // R8
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr_o |-> time_hold_o);

  // R8
  par_year_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr_o && !time_year_wr_o |-> time_o[DATA_W-1:PAR_DATA_W] == '0);

endmodule

// File: tb/rtc_cmd_frontend_bench.sv
`timescale 1ns/1ps
module rtc_cmd_frontend_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'b000;
  logic        din = 1'b0, dclk = 1'b0, stb = 1'b0, tick = 1'b0;
  logic [47:0] tin = '0;
  logic        dout, wr, ywr, hold;
  logic [47:0] tout;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [47:0] cap_time = '0;
  logic        cap_year = 1'b0;
  bit          done = 1'b0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];
  event  smp_ev;

  always #2 clk = ~clk;

  rtc_cmd_frontend u_rtc_cmd_frontend (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .data_i(din), .data_clk_i(dclk),
    .strobe_i(stb), .tick_1hz_i(tick), .time_i(tin), .data_o(dout),
    .time_o(tout), .time_wr_o(wr), .time_year_wr_o(ywr), .time_hold_o(hold)
  );

  always @(negedge clk) if (wr) begin
    wr_cnt++; cap_time = tout; cap_year = ywr;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected serial output bits
  always @(smp_ev) begin
    item_t it;
    it = sb_q.pop_front();
    chk(it.tag, {63'd0, dout}, {63'd0, it.exp});
  end

  task automatic expect_bit(input logic e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    ->smp_ev;
    #1;
  endtask

  task automatic settle(); repeat (8) @(negedge clk); endtask

  task automatic strobe(input logic [2:0] c);
    cmd = c; settle(); stb = 1'b1; settle(); stb = 1'b0; settle();
  endtask

  task automatic dpulse(input logic b);
    din = b; settle(); dclk = 1'b1; settle(); dclk = 1'b0; settle();
  endtask

  task automatic load_ser(input logic [3:0] c);
    for (int i = 0; i < 4; i++) dpulse(c[i]);
  endtask

  task automatic tick_check(input string tag);
    tick = 1'b1; settle(); expect_bit(1'b1, tag);
    tick = 1'b0; settle(); expect_bit(1'b0, tag);
  endtask

  localparam logic [39:0] P = 40'hA53C960FE1;
  localparam logic [39:0] T = 40'h5AC369F01E;
  localparam logic [47:0] Q = 48'h123456789ABC;
  localparam logic [47:0] U = 48'hF0E1D2C3B4A5;

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    tick_check("R1 hold after reset");
    chk("R1 hold low", {63'd0, hold}, 64'd0);
    chk("R1 time_o zero", {16'd0, tout}, 64'd0);

    // R4 parallel shift of P
    strobe(3'b001);
    for (int i = 0; i < 40; i++) dpulse(P[i]);
    expect_bit(P[0], "R4 lsb after 40 shifts");
    // R8 parallel time set
    w0 = wr_cnt;
    strobe(3'b010);
    chk("R8 one write pulse", 64'(wr_cnt - w0), 64'd1);
    chk("R8 parallel set value", {16'd0, cap_time}, {24'd0, P});
    chk("R8 no year write", {63'd0, cap_year}, 64'd0);
    chk("R8 hold high", {63'd0, hold}, 64'd1);
    expect_bit(P[0], "R7 lsb in time set");
    dpulse(~P[0]);
    expect_bit(P[0], "R10 locked after set");

    // R9 parallel time read
    tin = {8'hFF, T};
    strobe(3'b011);
    chk("R8 hold released", {63'd0, hold}, 64'd0);
    tick_check("R7 tick in time read");
    strobe(3'b001);
    for (int i = 0; i < 40; i++) begin
      expect_bit(T[i], "R9 parallel readout");
      dpulse(1'b0);
    end

    // R2 codes 1xx select hold
    strobe(3'b101);
    tick_check("R2 code 101 is hold");

    // R3 escape, load serial command 0001, R6 creg shifts in hold
    strobe(3'b111);
    tick_check("R3 extended hold");
    load_ser(4'b0001);
    strobe(3'b111);
    // R5 52-bit chain: 48 data then command 0010
    for (int i = 0; i < 48; i++) dpulse(Q[i]);
    load_ser(4'b0010);
    expect_bit(Q[0], "R5 lsb after chain");
    w0 = wr_cnt;
    strobe(3'b111);
    chk("R8 serial write pulse", 64'(wr_cnt - w0), 64'd1);
    chk("R5 serial set value", {16'd0, cap_time}, {16'd0, Q});
    chk("R8 year write", {63'd0, cap_year}, 64'd1);

    // R6 creg shifts in time set mode; R9 serial read
    load_ser(4'b0011);
    tin = U;
    strobe(3'b111);
    tick_check("R7 extended read tick");
    // R10 data register locked while creg loads
    load_ser(4'b0001);
    strobe(3'b111);
    for (int i = 0; i < 48; i++) begin
      expect_bit(U[i], "R9 R10 serial readout");
      dpulse(1'b0);
    end

    // R3 undefined extended code selects hold
    load_ser(4'b0101);
    strobe(3'b111);
    tick_check("R3 code 0101 is hold");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule